// File: doc/BRIEF.md
# Clock-Control Register Bank with Emulated PLL Lock

This block is the register file of a clock control unit, reduced to storage. It holds 32-bit words for the PLL controls, the bus dividers, the DRAM configuration, the PLL settle timers, and the PLL bias and tuning words. A simple slave port reaches it. Each access is one word wide: the request strobe is high for one clock edge, with a write-enable, a byte address and write data. Read data and an error flag come back one edge later.

Nothing downstream synthesises clocks. Two values are adjusted when they are written. A PLL control word written with its enable bit set is stored with its lock bit set, so firmware that polls for lock moves on at once. A write to the DRAM configuration word clears its update-request bit, which reads as if the update had already been taken. The address window ends at byte 0x308. Above it, reads return zero, writes are dropped, and the error flag pulses.

Top module: `clkctl_regbank`

## Requirements
- R1: After a synchronous active-low reset, the PLL control words read as follows. Byte 0x000 and byte 0x020 read 0x00001000. Byte 0x008 reads 0x00035514. Bytes 0x010, 0x018, 0x038 and 0x048 read 0x03006207. Bytes 0x028 and 0x044 read 0x00041811. Reset also clears `rdata` and `err`.
- R2: After reset, the remaining words read as follows. Bus and system words: 0x050=0x00010000, 0x054=0x00001010, 0x058=0x01000000, 0x0FC=0x80000000. Settle timers: 0x200=0x000000FF, 0x204=0x000000FF. Bias and tuning words: 0x220=0x08100200, 0x230=0x81104000, 0x234 and 0x244=0x10100010, 0x224/0x228/0x22C/0x23C/0x248=0x10100000, 0x250=0x0A101000, 0x260=0x14880000. Every other word below 0x308 reads 0.
- R3: A write to a PLL control word (byte offsets 0x000, 0x008, 0x010, 0x018, 0x020, 0x028, 0x038, 0x044, 0x048) with bit 31 set stores the data with bit 28 forced to 1.
- R4: A write to a PLL control word with bit 31 clear stores the data exactly, bit 28 included.
- R5: A write to byte 0x0F4 stores the data with bit 16 cleared. Bit 31 has no special effect there.
- R6: A write to any other word below 0x308 stores the data unchanged, whatever bit 31 holds.
- R7: A read at byte 0x308 or above returns 0 on `rdata`.
- R8: A write at byte 0x308 or above changes no stored word. Any request at byte 0x308 or above sets `err` for exactly the following cycle.
- R9: Read data for a request at edge N is on `rdata` after edge N and holds until the next read. `err` stays low after an in-range request or an idle cycle.
- R10: Address bits [1:0] are ignored. The word index is the byte address divided by four.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Access request, one word per high edge |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 12 | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| err | output | 1 | Out-of-window access flag, one cycle |

## Verification
The write adjustments, the read value and the error flag each have a fixed latency. A written word is visible to a read issued on the very next edge. `rdata` and `err` take the result of a request on the same rising edge that samples it. The bench therefore drives each request on a falling edge and reads both outputs on the following falling edge, half a period after they update. To check that `err` lasts one cycle, the bench samples one further falling edge with the request low. The checker's properties use the same timing: a write on one edge, a read of the same word on the next, and the data checked on the edge after that.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;

  localparam int unsigned DATA_W       = 32;
  localparam int unsigned PLL_EN_BIT   = 31;
  localparam int unsigned PLL_LOCK_BIT = 28;
  localparam int unsigned DRAM_UPD_BIT = 16;
  localparam int unsigned DRAM_CFG_OFF = 32'h0F4;

  typedef enum logic [1:0] {
    KIND_PLAIN = 2'd0,
    KIND_PLL   = 2'd1,
    KIND_DRAM  = 2'd2
  } wr_kind_e;

  // True for the byte offsets of the PLL control words
  function automatic logic is_pll_off(input int unsigned off);
    case (off)
      32'h000, 32'h008, 32'h010, 32'h018, 32'h020,
      32'h028, 32'h038, 32'h044, 32'h048: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // Value loaded into a word by reset, keyed by byte offset
  function automatic logic [DATA_W-1:0] reset_value(input int unsigned off);
    case (off)
      32'h000, 32'h020:                 return 32'h0000_1000;
      32'h008:                          return 32'h0003_5514;
      32'h010, 32'h018, 32'h038, 32'h048: return 32'h0300_6207;
      32'h028, 32'h044:                 return 32'h0004_1811;
      32'h050:                          return 32'h0001_0000;
      32'h054:                          return 32'h0000_1010;
      32'h058:                          return 32'h0100_0000;
      32'h0FC:                          return 32'h8000_0000;
      32'h200, 32'h204:                 return 32'h0000_00FF;
      32'h220:                          return 32'h0810_0200;
      32'h230:                          return 32'h8110_4000;
      32'h234, 32'h244:                 return 32'h1010_0010;
      32'h224, 32'h228, 32'h22C,
      32'h23C, 32'h248:                 return 32'h1010_0000;
      32'h250:                          return 32'h0A10_1000;
      32'h260:                          return 32'h1488_0000;
      default:                          return '0;
    endcase
  endfunction

  // Write-side adjustment applied before a word is stored
  function automatic logic [DATA_W-1:0] adjust_write(input wr_kind_e kind,
                                                     input logic [DATA_W-1:0] d);
    logic [DATA_W-1:0] r;
    r = d;
    case (kind)
      KIND_PLL:  if (d[PLL_EN_BIT]) r[PLL_LOCK_BIT] = 1'b1;
      KIND_DRAM: r[DRAM_UPD_BIT] = 1'b0;
      default:   r = d;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/clkctl_decode.sv
module clkctl_decode #(
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned LIMIT_BYTES = 32'h308,
  parameter int unsigned IDX_W       = 8
) (
  input  logic [ADDR_W-1:0]     addr,
  output logic [IDX_W-1:0]      idx,
  output logic                  in_range,
  output clkctl_pkg::wr_kind_e  kind
);
  import clkctl_pkg::*;

  logic [ADDR_W-1:0] aligned;
  logic [ADDR_W-1:0] word_no;

  assign aligned  = addr & ~ADDR_W'(3);
  assign word_no  = aligned >> 2;
  assign idx      = IDX_W'(word_no);
  assign in_range = (32'(aligned) < LIMIT_BYTES);

  always_comb begin
    if (is_pll_off(32'(aligned)))           kind = KIND_PLL;
    else if (32'(aligned) == DRAM_CFG_OFF)  kind = KIND_DRAM;
    else                                    kind = KIND_PLAIN;
  end

endmodule

// File: rtl/clkctl_wr_adjust.sv
module clkctl_wr_adjust #(
  parameter int unsigned DATA_W = 32
) (
  input  clkctl_pkg::wr_kind_e  kind,
  input  logic [DATA_W-1:0]     din,
  output logic [DATA_W-1:0]     dout
);
  assign dout = clkctl_pkg::adjust_write(kind, din);
endmodule

// File: rtl/clkctl_store.sv
module clkctl_store #(
  parameter int unsigned NUM_WORDS = 194,
  parameter int unsigned IDX_W     = 8,
  parameter int unsigned DATA_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] words [NUM_WORDS];

  always_ff @(posedge clk) begin
    for (int i = 0; i < int'(NUM_WORDS); i++) begin
      if (!rst_n)
        words[i] <= clkctl_pkg::reset_value(32'(i) * 4);
      else if (wr_en && (wr_idx == IDX_W'(i)))
        words[i] <= wr_data;
    end
  end

  assign rd_data = (32'(rd_idx) < NUM_WORDS) ? words[rd_idx] : '0;

endmodule

// File: rtl/clkctl_regbank.sv
module clkctl_regbank #(
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned LIMIT_BYTES = 32'h308
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic        we,
  input  logic [11:0] addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        err
);
  import clkctl_pkg::*;

  localparam int unsigned NUM_WORDS = LIMIT_BYTES / 4;
  localparam int unsigned IDX_W     = $clog2(NUM_WORDS);

  // Named internal events
  logic                 acc_in_range;
  logic [IDX_W-1:0]     acc_idx;
  wr_kind_e             acc_kind;
  logic [DATA_W-1:0]    store_wdata;
  logic                 store_wr;
  logic                 rd_evt;
  logic                 oob_evt;
  logic [DATA_W-1:0]    store_rdata;
  logic [DATA_W-1:0]    rdata_q;
  logic                 err_q;

  clkctl_decode #(
    .ADDR_W(ADDR_W), .LIMIT_BYTES(LIMIT_BYTES), .IDX_W(IDX_W)
  ) dec_i (
    .addr(addr[ADDR_W-1:0]), .idx(acc_idx), .in_range(acc_in_range), .kind(acc_kind)
  );

  clkctl_wr_adjust #(.DATA_W(DATA_W)) adj_i (
    .kind(acc_kind), .din(wdata), .dout(store_wdata)
  );

  assign store_wr = req && we && acc_in_range;
  assign rd_evt   = req && !we;
  assign oob_evt  = req && !acc_in_range;

  clkctl_store #(
    .NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W), .DATA_W(DATA_W)
  ) store_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(store_wr), .wr_idx(acc_idx), .wr_data(store_wdata),
    .rd_idx(acc_idx), .rd_data(store_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q <= oob_evt;
      if (rd_evt)
        rdata_q <= acc_in_range ? store_rdata : '0;
    end
  end

  assign rdata = rdata_q;
  assign err   = err_q;

endmodule

// File: rtl/clkctl_regbank_chk.sv
module clkctl_regbank_chk #(
  parameter int unsigned LIMIT_BYTES = 32'h308
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req,
  input logic        we,
  input logic [11:0] addr,
  input logic [31:0] wdata,
  input logic [31:0] rdata,
  input logic        err
);
  logic [9:0] word;
  logic       oob;
  logic       pll_w;
  logic       dram_w;

  assign word   = addr[11:2];
  assign oob    = ({word, 2'b00} >= 12'(LIMIT_BYTES));
  assign pll_w  = clkctl_pkg::is_pll_off(32'({word, 2'b00}));
  assign dram_w = ({word, 2'b00} == 12'h0F4);

  // R8: an out-of-window request raises err on the next cycle
  a_r8_err_after_oob: assert property (@(posedge clk) disable iff (!rst_n)
    req && oob |=> err);

  // R8: err never outlasts its request
  a_r8_err_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !err);

  // R9: in-window requests leave err low
  a_r9_no_err_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    req && !oob |=> !err);

  // R9: rdata holds when no read is issued
  a_r9_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(req && !we) |=> $stable(rdata));

  // R7: out-of-window reads return zero
  a_r7_oob_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    req && !we && oob |=> rdata == 32'h0);

  // R3: enable written into a PLL word reads back with lock set
  a_r3_lock_on_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(req && we && !oob && pll_w && wdata[31]) &&
    req && !we && word == $past(word) |=> rdata[28]);

  // R5: DRAM configuration reads back with the update bit clear
  a_r5_update_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(req && we && dram_w) &&
    req && !we && word == $past(word) |=> !rdata[16]);

  // R6: plain words read back exactly as written
  a_r6_plain_store: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(req && we && !oob && !pll_w && !dram_w) &&
    req && !we && word == $past(word) |=> rdata == $past(wdata, 2));

endmodule

bind clkctl_regbank clkctl_regbank_chk #(.LIMIT_BYTES(LIMIT_BYTES)) chk_i (
  .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
  .wdata(wdata), .rdata(rdata), .err(err)
);

// File: tb/clkctl_regbank_tb_top.sv
module clkctl_regbank_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        err;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  clkctl_regbank dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
    .wdata(wdata), .rdata(rdata), .err(err)
  );

  // Expected reset contents, restated from R1/R2
  function automatic logic [31:0] exp_rst(input int off);
    case (off)
      'h000: return 32'h00001000;  'h020: return 32'h00001000;
      'h008: return 32'h00035514;
      'h010: return 32'h03006207;  'h018: return 32'h03006207;
      'h038: return 32'h03006207;  'h048: return 32'h03006207;
      'h028: return 32'h00041811;  'h044: return 32'h00041811;
      'h050: return 32'h00010000;  'h054: return 32'h00001010;
      'h058: return 32'h01000000;  'h0FC: return 32'h80000000;
      'h200: return 32'h000000FF;  'h204: return 32'h000000FF;
      'h220: return 32'h08100200;  'h230: return 32'h81104000;
      'h234: return 32'h10100010;  'h244: return 32'h10100010;
      'h224: return 32'h10100000;  'h228: return 32'h10100000;
      'h22C: return 32'h10100000;  'h23C: return 32'h10100000;
      'h248: return 32'h10100000;
      'h250: return 32'h0A101000;  'h260: return 32'h14880000;
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic do_read(input logic [11:0] a, output logic [31:0] d, output logic e);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    req = 1'b0;
    d = rdata; e = err;
  endtask

  task automatic t_reset_image;
    logic [31:0] d; logic e;
    check("R1 rdata after reset", rdata, 32'h0);
    check("R1 err after reset", {31'h0, err}, 32'h0);
    for (int off = 0; off < 'h308; off += 4) begin
      do_read(12'(off), d, e);
      if (off < 'h04C) check($sformatf("R1 reset @%03h", off), d, exp_rst(off));
      else             check($sformatf("R2 reset @%03h", off), d, exp_rst(off));
    end
  endtask

  task automatic t_pll_lock;
    logic [31:0] d; logic e;
    do_write(12'h044, 32'h8000_0000);
    do_read(12'h044, d, e);
    check("R3 lock forced @044", d, 32'h9000_0000);
    do_write(12'h000, 32'h8000_1234);
    do_read(12'h000, d, e);
    check("R3 lock forced @000", d, 32'h9000_1234);
    do_write(12'h048, 32'hFFFF_FFFF);
    do_read(12'h048, d, e);
    check("R3 all ones @048", d, 32'hFFFF_FFFF);
  endtask

  task automatic t_pll_plain;
    logic [31:0] d; logic e;
    do_write(12'h010, 32'h1000_0055);
    do_read(12'h010, d, e);
    check("R4 lock bit kept @010", d, 32'h1000_0055);
    do_write(12'h038, 32'h0000_0001);
    do_read(12'h038, d, e);
    check("R4 no lock @038", d, 32'h0000_0001);
  endtask

  task automatic t_dram;
    logic [31:0] d; logic e;
    do_write(12'h0F4, 32'hFFFF_FFFF);
    do_read(12'h0F4, d, e);
    check("R5 update cleared", d, 32'hFFFE_FFFF);
    do_write(12'h0F4, 32'h8001_0000);
    do_read(12'h0F4, d, e);
    check("R5 no lock on dram", d, 32'h8000_0000);
  endtask

  task automatic t_plain;
    logic [31:0] d; logic e;
    do_write(12'h054, 32'h1234_5678);
    do_read(12'h054, d, e);
    check("R6 store @054", d, 32'h1234_5678);
    do_write(12'h04C, 32'h8000_0000);
    do_read(12'h04C, d, e);
    check("R6 no lock @04C", d, 32'h8000_0000);
    do_write(12'h304, 32'hDEAD_BEEF);
    do_read(12'h304, d, e);
    check("R6 last word", d, 32'hDEAD_BEEF);
    check("R9 no err in range", {31'h0, e}, 32'h0);
  endtask

  task automatic t_oob;
    logic [31:0] d; logic e;
    do_read(12'h308, d, e);
    check("R7 oob read zero", d, 32'h0);
    check("R8 err on oob read", {31'h0, e}, 32'h1);
    @(negedge clk);
    check("R8 err one cycle", {31'h0, err}, 32'h0);
    do_read(12'hFFC, d, e);
    check("R7 top read zero", d, 32'h0);
    do_write(12'h454, 32'hCAFE_F00D);
    check("R8 err on oob write", {31'h0, err}, 32'h1);
    do_read(12'h054, d, e);
    check("R8 no alias write", d, 32'h1234_5678);
    do_read(12'h304, d, e);
    check("R8 last word kept", d, 32'hDEAD_BEEF);
  endtask

  task automatic t_hold_align;
    logic [31:0] d; logic e;
    do_read(12'h0FE, d, e);
    check("R10 unaligned read", d, 32'h8000_0000);
    repeat (3) @(negedge clk);
    check("R9 rdata holds", rdata, 32'h8000_0000);
    do_write(12'h201, 32'h0000_ABCD);
    do_read(12'h200, d, e);
    check("R10 unaligned write", d, 32'h0000_ABCD);
    do_read(12'h204, d, e);
    check("R10 neighbour intact", d, 32'h0000_00FF);
  endtask

  task automatic t_rereset;
    logic [31:0] d; logic e;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    check("R1 rdata cleared", rdata, 32'h0);
    do_read(12'h044, d, e);
    check("R1 pll restored", d, 32'h0004_1811);
    do_read(12'h0F4, d, e);
    check("R2 dram restored", d, 32'h0);
    do_read(12'h054, d, e);
    check("R2 bus restored", d, 32'h0000_1010);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_image();
    t_pll_lock();
    t_pll_plain();
    t_dram();
    t_plain();
    t_oob();
    t_hold_align();
    t_rereset();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule